// File: doc/BRIEF.md
# SD/MMC Host Command Sequencer

This block is the command-line engine of an SD/MMC host. Software writes a 32-bit argument, then a command word; that write starts a transaction. The block serializes a 48-bit command frame onto the command line, one bit per clock of the card-rate clock. It then listens for the card's reply, which may be absent, 48 bits or 136 bits long. It checks the reply's end bit, and also its CRC7 and echoed index when the command word asks for those checks. Finally it posts the outcome in a write-one-to-clear status register.

The command word carries the command index in bits 29:24 and a 2-bit response type in bits 17:16. It also holds enable bits for the CRC check and the index check, a data-present flag and a transfer direction. A command with the busy response type holds completion back until the card releases DAT0. A command flagged as data-present produces a one-cycle hand-off pulse to the data engine when it completes. An initialization mode replaces the frame with a long run of driven ones so the card can wake up. Software issues two such commands back to back and then leaves the mode.

Register map (address, read / write): 0 argument (R/W); 1 command word (R/W, write starts); 2 status (R / W1C); 3 control (bit 0 init mode R/W, bit 8 command inhibit R, bit 9 data inhibit R); 4..7 response words 0..3 (R).

Top module: `sd_cmd_seq`

## Requirements
- R1: A write to address 1 while idle drives cmdOe high for exactly 48 cycles. cmdOut carries, MSB first, 0, 1, the command index (command word bits 29:24), the 32-bit argument, a CRC7 over those first 40 bits (polynomial x^7+x^3+1, zero seed), then 1.
- R2: With response type 00 (bits 17:16), status bit 0 (command done) is set in the cycle after the end bit, and no reply is awaited.
- R3: With response type 10, a reply starting with a 0 on cmdIn is shifted in for 48 bits. Response word 0 then holds reply bits 39:8, words 1..3 read zero, and command done is set.
- R4: With response type 01, a 136-bit reply is captured so that response word k holds reply bits 32k+31:32k.
- R5: When command word bit 19 is set, a CRC7 mismatch in the reply sets status bit 17. When bit 19 is clear, the same reply leaves bit 17 at 0. For long replies the CRC covers reply bits 127:8.
- R6: When command word bit 20 is set, a 48-bit reply whose bits 45:40 differ from the command index sets status bit 19. The index check never applies to a 136-bit reply.
- R7: A reply whose last bit is 0 sets status bit 18.
- R8: If cmdIn shows no 0 within 64 cycles after the end bit, status bit 16 (timeout) is set, command done stays 0, and the block returns to idle. A start bit on the 64th cycle is still accepted.
- R9: With response type 11, command done is withheld while dat0In is low after the reply. Control bit 9 reads 1 during that wait. Done is set once dat0In is high.
- R10: Control bit 8 reads 1 whenever a command is in progress. A write to address 1 at that time is ignored and produces no frame.
- R11: Writing 1 to a status bit clears only that bit. Status bit 15 reads as the OR of bits 19:16. Status and control read zero after reset.
- R12: With control bit 0 set, a command write drives cmdOut high with cmdOe for INIT_LEN cycles. Command done is then set and no reply is awaited.
- R13: A completed command with bit 21 (data present) set pulses xferGo for one cycle, with xferRead equal to command word bit 4. Commands without bit 21 give no pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Card-rate clock, one command bit per cycle |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 3 | Register write address |
| wrData | input | 32 | Register write data |
| rdAddr | input | 3 | Register read address |
| rdData | output | 32 | Register read data (combinational) |
| cmdOut | output | 1 | Command line output value |
| cmdOe | output | 1 | Command line output enable |
| cmdIn | input | 1 | Command line input from the card |
| dat0In | input | 1 | DAT0 level, low while the card is busy |
| xferGo | output | 1 | One-cycle pulse starting the data phase |
| xferRead | output | 1 | Direction of that data phase, 1 for read |

## Verification
The hardest state to reach is the busy wait after a 48-bit reply. There a second command write must be refused while the command line is silent and nothing else shows the block is occupied. The bench holds dat0In low before issuing the busy-type command and plays back a clean reply. It then writes a new command while the block waits, and confirms that no frame appears and that both inhibit bits read 1. Only after that does it release DAT0. The timeout edge is reached by delaying the card model's start bit by exactly 63 and 64 cycles.

// File: rtl/sd_cmd_pkg.sv
package sd_cmd_pkg;
  localparam int FRAME_BITS = 48;
  localparam int LONG_BITS  = 136;

  localparam logic [2:0] A_ARG  = 3'd0;
  localparam logic [2:0] A_CMD  = 3'd1;
  localparam logic [2:0] A_STAT = 3'd2;
  localparam logic [2:0] A_CTRL = 3'd3;

  localparam int B_DIR    = 4;
  localparam int B_CRCCHK = 19;
  localparam int B_IDXCHK = 20;
  localparam int B_DP     = 21;

  typedef enum logic [1:0] {
    RSP_NONE  = 2'b00,
    RSP_LONG  = 2'b01,
    RSP_SHORT = 2'b10,
    RSP_BUSY  = 2'b11
  } rsp_e;

  typedef enum logic [2:0] {
    S_IDLE, S_INIT, S_TX, S_WAIT, S_RX, S_CHK, S_BUSY
  } state_e;

  typedef struct packed {
    logic accept;
    logic shiftTx;
    logic shiftRx;
    logic evalRsp;
    logic setDone;
    logic setTimeout;
  } strobe_t;

  // CRC7 (x^7+x^3+1) over the low nBits of d, MSB first
  function automatic logic [6:0] crc7(input logic [119:0] d, input int nBits);
    logic [6:0] c;
    logic fb;
    c = '0;
    for (int i = 119; i >= 0; i--) begin
      if (i < nBits) begin
        fb = d[i] ^ c[6];
        c  = {c[5:0], 1'b0};
        if (fb) c = c ^ 7'h09;
      end
    end
    return c;
  endfunction
endpackage

// File: rtl/sd_cmd_ctrl.sv
module sd_cmd_ctrl
  import sd_cmd_pkg::*;
#(
  parameter int TIMEOUT_CYC = 64,
  parameter int INIT_LEN    = 80
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    cmdWr,
  input  logic    initMode,
  input  logic    cmdIn,
  input  logic    dat0In,
  input  rsp_e    rspType,
  output strobe_t stb,
  output logic    cmdOe,
  output logic    cmdBusy,
  output logic    dataBusy
);
  localparam int MAX_A  = (INIT_LEN > LONG_BITS) ? INIT_LEN : LONG_BITS;
  localparam int MAX_C  = (TIMEOUT_CYC > MAX_A) ? TIMEOUT_CYC : MAX_A;
  localparam int CNT_W  = $clog2(MAX_C + 1);

  state_e st, stNext;
  logic [CNT_W-1:0] cnt, cntNext;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      st  <= S_IDLE;
      cnt <= '0;
    end else begin
      st  <= stNext;
      cnt <= cntNext;
    end
  end

  always_comb begin
    stb     = '0;
    stNext  = st;
    cntNext = cnt;
    case (st)
      S_IDLE: if (cmdWr) begin
        stb.accept = 1'b1;
        if (initMode) begin
          stNext  = S_INIT;
          cntNext = CNT_W'(INIT_LEN - 1);
        end else begin
          stNext  = S_TX;
          cntNext = CNT_W'(FRAME_BITS - 1);
        end
      end
      S_INIT: begin
        stb.shiftTx = 1'b1;
        if (cnt == '0) begin
          stb.setDone = 1'b1;
          stNext      = S_IDLE;
        end else cntNext = cnt - 1'b1;
      end
      S_TX: begin
        stb.shiftTx = 1'b1;
        if (cnt != '0) cntNext = cnt - 1'b1;
        else if (rspType == RSP_NONE) begin
          stb.setDone = 1'b1;
          stNext      = S_IDLE;
        end else begin
          stNext  = S_WAIT;
          cntNext = '0;
        end
      end
      S_WAIT: begin
        if (!cmdIn) begin
          stb.shiftRx = 1'b1;
          stNext      = S_RX;
          cntNext     = (rspType == RSP_LONG) ? CNT_W'(LONG_BITS - 2)
                                              : CNT_W'(FRAME_BITS - 2);
        end else if (cnt == CNT_W'(TIMEOUT_CYC - 1)) begin
          stb.setTimeout = 1'b1;
          stNext         = S_IDLE;
        end else cntNext = cnt + 1'b1;
      end
      S_RX: begin
        stb.shiftRx = 1'b1;
        if (cnt == '0) stNext = S_CHK;
        else cntNext = cnt - 1'b1;
      end
      S_CHK: begin
        stb.evalRsp = 1'b1;
        if (rspType == RSP_BUSY) stNext = S_BUSY;
        else begin
          stb.setDone = 1'b1;
          stNext      = S_IDLE;
        end
      end
      S_BUSY: if (dat0In) begin
        stb.setDone = 1'b1;
        stNext      = S_IDLE;
      end
      default: stNext = S_IDLE;
    endcase
  end

  assign cmdOe    = (st == S_TX) || (st == S_INIT);
  assign cmdBusy  = (st != S_IDLE);
  assign dataBusy = (st == S_BUSY);
endmodule

// File: rtl/sd_cmd_dp.sv
module sd_cmd_dp
  import sd_cmd_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        wrEn,
  input  logic [2:0]  wrAddr,
  input  logic [31:0] wrData,
  input  logic [2:0]  rdAddr,
  output logic [31:0] rdData,
  input  strobe_t     stb,
  input  logic        cmdBusy,
  input  logic        dataBusy,
  input  logic        cmdIn,
  output logic        cmdOut,
  output logic        initMode,
  output rsp_e        rspType,
  output logic        xferGo,
  output logic        xferRead
);
  logic [31:0] argReg, cmdReg;
  logic [FRAME_BITS-1:0] txSh, txFrame;
  logic [127:0] rx, rsp;
  logic done, toErr, crcErr, endErr, idxErr;
  logic isLong, crcBad, idxBad, endBad, statWr;
  logic [6:0] txCrc, rxCrc;

  assign txCrc   = crc7({80'b0, 2'b01, wrData[29:24], argReg}, 40);
  assign txFrame = {2'b01, wrData[29:24], argReg, txCrc, 1'b1};

  assign rspType = rsp_e'(cmdReg[17:16]);
  assign isLong  = (rspType == RSP_LONG);
  assign rxCrc   = isLong ? crc7(rx[127:8], 120) : crc7({80'b0, rx[47:8]}, 40);
  assign crcBad  = (rxCrc != rx[7:1]);
  assign idxBad  = !isLong && (rx[45:40] != cmdReg[29:24]);
  assign endBad  = !rx[0];
  assign statWr  = wrEn && (wrAddr == A_STAT);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      argReg   <= '0;
      cmdReg   <= '0;
      initMode <= 1'b0;
      txSh     <= '1;
      rx       <= '0;
      rsp      <= '0;
      done     <= 1'b0;
      toErr    <= 1'b0;
      crcErr   <= 1'b0;
      endErr   <= 1'b0;
      idxErr   <= 1'b0;
      xferGo   <= 1'b0;
      xferRead <= 1'b0;
    end else begin
      if (wrEn && wrAddr == A_ARG)  argReg   <= wrData;
      if (wrEn && wrAddr == A_CTRL) initMode <= wrData[0];
      if (stb.accept) begin
        cmdReg <= wrData;
        txSh   <= initMode ? '1 : txFrame;
      end else if (stb.shiftTx) begin
        txSh <= {txSh[FRAME_BITS-2:0], 1'b1};
      end
      if (stb.shiftRx) rx <= {rx[126:0], cmdIn};
      if (stb.evalRsp) rsp <= isLong ? rx : {96'b0, rx[39:8]};

      done   <= stb.setDone | (done & ~(statWr & wrData[0]));
      toErr  <= stb.setTimeout | (toErr & ~(statWr & wrData[16]));
      crcErr <= (stb.evalRsp & cmdReg[B_CRCCHK] & crcBad) | (crcErr & ~(statWr & wrData[17]));
      endErr <= (stb.evalRsp & endBad) | (endErr & ~(statWr & wrData[18]));
      idxErr <= (stb.evalRsp & cmdReg[B_IDXCHK] & idxBad) | (idxErr & ~(statWr & wrData[19]));

      xferGo <= stb.setDone & cmdReg[B_DP];
      if (stb.setDone) xferRead <= cmdReg[B_DIR];
    end
  end

  assign cmdOut = txSh[FRAME_BITS-1];

  always_comb begin
    case (rdAddr)
      A_ARG:   rdData = argReg;
      A_CMD:   rdData = cmdReg;
      A_STAT:  rdData = {12'b0, idxErr, endErr, crcErr, toErr,
                         (idxErr | endErr | crcErr | toErr), 14'b0, done};
      A_CTRL:  rdData = {22'b0, dataBusy, cmdBusy, 7'b0, initMode};
      default: rdData = rsp[{rdAddr[1:0], 5'b0} +: 32];
    endcase
  end
endmodule

// File: rtl/sd_cmd_seq.sv
module sd_cmd_seq
  import sd_cmd_pkg::*;
#(
  parameter int TIMEOUT_CYC = 64,
  parameter int INIT_LEN    = 80
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        wrEn,
  input  logic [2:0]  wrAddr,
  input  logic [31:0] wrData,
  input  logic [2:0]  rdAddr,
  output logic [31:0] rdData,
  output logic        cmdOut,
  output logic        cmdOe,
  input  logic        cmdIn,
  input  logic        dat0In,
  output logic        xferGo,
  output logic        xferRead
);
  strobe_t stb;
  rsp_e    rspType;
  logic    initMode, cmdBusy, dataBusy, cmdWr;

  assign cmdWr = wrEn && (wrAddr == A_CMD);

  sd_cmd_ctrl #(.TIMEOUT_CYC(TIMEOUT_CYC), .INIT_LEN(INIT_LEN)) uCtrl (
    .clk(clk), .rstN(rstN), .cmdWr(cmdWr), .initMode(initMode),
    .cmdIn(cmdIn), .dat0In(dat0In), .rspType(rspType), .stb(stb),
    .cmdOe(cmdOe), .cmdBusy(cmdBusy), .dataBusy(dataBusy)
  );

  sd_cmd_dp uDp (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData), .stb(stb), .cmdBusy(cmdBusy),
    .dataBusy(dataBusy), .cmdIn(cmdIn), .cmdOut(cmdOut), .initMode(initMode),
    .rspType(rspType), .xferGo(xferGo), .xferRead(xferRead)
  );
endmodule

// File: rtl/sd_cmd_seq_chk.sv
module sd_cmd_seq_chk #(
  parameter int FRAME_BITS = 48,
  parameter int INIT_LEN   = 80
) (
  input logic clk,
  input logic rstN,
  input logic cmdOe,
  input logic cmdBusy,
  input logic dataBusy,
  input logic dat0In,
  input logic xferGo
);
  int oeRun;

  always_ff @(posedge clk) begin
    if (!rstN) oeRun <= 0;
    else if (cmdOe) oeRun <= oeRun + 1;
    else oeRun <= 0;
  end

  AST_DRIVE_LENGTH: assert property (@(posedge clk) disable iff (!rstN)
    $fell(cmdOe) |-> (oeRun == FRAME_BITS || oeRun == INIT_LEN)); // R1

  AST_DRIVE_IMPLIES_INHIBIT: assert property (@(posedge clk) disable iff (!rstN)
    cmdOe |-> cmdBusy); // R10

  AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (dataBusy && !dat0In) |=> dataBusy); // R9

  AST_BUSY_LINE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    dataBusy |-> !cmdOe); // R9

  AST_XFER_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    xferGo |=> !xferGo); // R13

  AST_XFER_AFTER_CMD: assert property (@(posedge clk) disable iff (!rstN)
    xferGo |-> !cmdBusy); // R13
endmodule

bind sd_cmd_seq sd_cmd_seq_chk #(.FRAME_BITS(48), .INIT_LEN(INIT_LEN)) uChk (
  .clk(clk), .rstN(rstN), .cmdOe(cmdOe), .cmdBusy(cmdBusy),
  .dataBusy(dataBusy), .dat0In(dat0In), .xferGo(xferGo)
);

// File: tb/sim_sd_cmd_seq.sv
module sim_sd_cmd_seq;
  localparam int CLK_PERIOD = 10;
  localparam int INIT_LEN   = 80;
  localparam int TIMEOUT    = 64;

  logic clk = 1'b0, rstN = 1'b0, wrEn = 1'b0;
  logic [2:0] wrAddr = '0, rdAddr = '0;
  logic [31:0] wrData = '0, rdData;
  logic cmdOut, cmdOe, cmdIn = 1'b1, dat0In = 1'b1, xferGo, xferRead;

  int nChk = 0, nFail = 0, xferCnt = 0;
  logic lastDir = 1'b0;
  logic expQ[$];

  sd_cmd_seq #(.TIMEOUT_CYC(TIMEOUT), .INIT_LEN(INIT_LEN)) u0 (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData), .cmdOut(cmdOut), .cmdOe(cmdOe),
    .cmdIn(cmdIn), .dat0In(dat0In), .xferGo(xferGo), .xferRead(xferRead)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // monitor: every driven bit is popped from the scoreboard queue
  always @(negedge clk) begin
    if (rstN && cmdOe) begin
      nChk++;
      if (expQ.size() == 0) begin
        nFail++;
        $display("FAIL R1/R10 unexpected drive act=%b exp=idle", cmdOut);
      end else begin
        logic e;
        e = expQ.pop_front();
        if (cmdOut !== e) begin
          nFail++;
          $display("FAIL R1 frame bit act=%b exp=%b", cmdOut, e);
        end
      end
    end
    if (rstN && xferGo) begin
      xferCnt++;
      lastDir = xferRead;
    end
  end

  function automatic logic [6:0] bcrc(input logic [119:0] v, input int n);
    logic [6:0] c = '0;
    for (int k = n - 1; k >= 0; k--) begin
      logic t;
      t = c[6] ^ v[k];
      c = {c[5:0], 1'b0};
      c[0] = c[0] ^ t;
      c[3] = c[3] ^ t;
    end
    return c;
  endfunction

  function automatic logic [31:0] mk(input int idx, input logic [1:0] rt, input logic cc,
                                    input logic ic, input logic dp, input logic dir);
    logic [31:0] w = '0;
    w[29:24] = idx[5:0];
    w[21] = dp; w[20] = ic; w[19] = cc; w[17:16] = rt; w[4] = dir;
    return w;
  endfunction

  function automatic logic [135:0] rsp48(input int idx, input logic [31:0] body,
                                        input logic crcOk, input logic endOk);
    logic [39:0] hd;
    logic [6:0] c;
    hd = {2'b00, idx[5:0], body};
    c = bcrc({80'b0, hd}, 40) ^ (crcOk ? 7'h00 : 7'h01);
    return {88'b0, hd, c, endOk};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    rdAddr = a;
    #1;
    d = rdData;
  endtask

  // driver: pushes the expected line activity, then starts the command
  task automatic issue(input logic [31:0] cw, input logic [31:0] arg, input logic initM);
    if (initM) begin
      for (int i = 0; i < INIT_LEN; i++) expQ.push_back(1'b1);
    end else begin
      logic [39:0] h;
      logic [47:0] f;
      wr(3'd0, arg);
      h = {2'b01, cw[29:24], arg};
      f = {h, bcrc({80'b0, h}, 40), 1'b1};
      for (int i = 47; i >= 0; i--) expQ.push_back(f[i]);
    end
    wr(3'd1, cw);
    while (cmdOe) @(negedge clk);
  endtask

  task automatic respond(input logic [135:0] bits, input int len, input int dly);
    for (int d = 0; d < dly; d++) begin cmdIn = 1'b1; @(negedge clk); end
    for (int i = len - 1; i >= 0; i--) begin cmdIn = bits[i]; @(negedge clk); end
    cmdIn = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic clearAll();
    wr(3'd2, 32'hFFFF_FFFF);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    nChk++; nFail++;
    $display("FAIL watchdog act=running exp=finished");
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
    $finish;
  end

  initial begin
    logic [31:0] v;
    logic [135:0] lr;
    logic [119:0] body;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    rd(3'd2, v); chk("R11 reset status", v, 32'h0);
    rd(3'd3, v); chk("R12 reset control", v, 32'h0);
    chk("R1 reset oe", {31'b0, cmdOe}, 32'h0);

    // R1 R2: no-response command
    issue(mk(0, 2'b00, 0, 0, 0, 0), 32'h0, 1'b0);
    rd(3'd2, v); chk("R2 done after frame", v, 32'h1);
    wr(3'd2, 32'h1);
    rd(3'd2, v); chk("R11 clear done", v, 32'h0);

    // R3: short reply with checks on
    issue(mk(8, 2'b10, 1, 1, 0, 0), 32'h0000_01AA, 1'b0);
    respond(rsp48(8, 32'h0000_01AA, 1, 1), 48, 2);
    rd(3'd2, v); chk("R3 status", v, 32'h1);
    rd(3'd4, v); chk("R3 rsp word0", v, 32'h0000_01AA);
    rd(3'd5, v); chk("R3 rsp word1 zero", v, 32'h0);
    clearAll();

    // R5: bad CRC with check on
    issue(mk(17, 2'b10, 1, 0, 0, 0), 32'h1234_5678, 1'b0);
    respond(rsp48(17, 32'hCAFE_F00D, 0, 1), 48, 5);
    rd(3'd2, v); chk("R5 crc error flagged", v, 32'h0002_8001);
    wr(3'd2, 32'h1);
    rd(3'd2, v); chk("R11 partial clear", v, 32'h0002_8000);
    clearAll();
    rd(3'd2, v); chk("R11 full clear", v, 32'h0);

    // R5: same bad CRC with check off
    issue(mk(17, 2'b10, 0, 0, 0, 0), 32'h1234_5678, 1'b0);
    respond(rsp48(17, 32'hCAFE_F00D, 0, 1), 48, 1);
    rd(3'd2, v); chk("R5 crc ignored when off", v, 32'h1);
    clearAll();

    // R6: index mismatch
    issue(mk(17, 2'b10, 1, 1, 0, 0), 32'h0, 1'b0);
    respond(rsp48(18, 32'h0000_0900, 1, 1), 48, 3);
    rd(3'd2, v); chk("R6 index error", v, 32'h0008_8001);
    clearAll();

    // R4 R6: long reply, index check bit set but not applied
    body = {32'hDEAD_BEEF, 32'h0123_4567, 32'h89AB_CDEF, 24'h55AA33};
    lr = {8'h3F, body, bcrc(body, 120), 1'b1};
    issue(mk(2, 2'b01, 1, 1, 0, 0), 32'h0, 1'b0);
    respond(lr, 136, 4);
    rd(3'd2, v); chk("R6 no index check on long", v, 32'h1);
    for (int k = 0; k < 4; k++) begin
      rd(3'(4 + k), v);
      chk("R4 long rsp word", v, lr[32*k +: 32]);
    end
    clearAll();

    // R7: bad end bit
    issue(mk(13, 2'b10, 1, 1, 0, 0), 32'h0, 1'b0);
    respond(rsp48(13, 32'h0000_0900, 1, 0), 48, 2);
    rd(3'd2, v); chk("R7 end bit error", v, 32'h0004_8001);
    clearAll();

    // R8: timeout at 64 silent cycles, accepted at 63
    issue(mk(5, 2'b10, 1, 1, 0, 0), 32'h0, 1'b0);
    respond('0, 0, TIMEOUT);
    rd(3'd2, v); chk("R8 timeout flagged", v, 32'h0001_8000);
    rd(3'd3, v); chk("R8 back to idle", v, 32'h0);
    clearAll();
    issue(mk(5, 2'b10, 1, 1, 0, 0), 32'h0, 1'b0);
    respond(rsp48(5, 32'h00FF_8000, 1, 1), 48, TIMEOUT - 1);
    rd(3'd2, v); chk("R8 late start accepted", v, 32'h1);
    clearAll();

    // R9 R10: busy wait, refused command
    dat0In = 1'b0;
    issue(mk(7, 2'b11, 1, 1, 0, 0), 32'h0, 1'b0);
    respond(rsp48(7, 32'h0000_0800, 1, 1), 48, 2);
    rd(3'd2, v); chk("R9 done withheld", v, 32'h0);
    rd(3'd3, v); chk("R9 R10 inhibits set", v, 32'h0000_0300);
    wr(3'd1, mk(9, 2'b00, 0, 0, 0, 0));
    repeat (4) @(negedge clk);
    chk("R10 refused command silent", {31'b0, cmdOe}, 32'h0);
    rd(3'd2, v); chk("R10 no completion", v, 32'h0);
    dat0In = 1'b1;
    repeat (2) @(negedge clk);
    rd(3'd2, v); chk("R9 done after release", v, 32'h1);
    rd(3'd3, v); chk("R9 inhibits clear", v, 32'h0);
    clearAll();

    // R12: init stream, two commands
    wr(3'd3, 32'h1);
    rd(3'd3, v); chk("R12 init mode set", v, 32'h1);
    for (int n = 0; n < 2; n++) begin
      issue(mk(0, 2'b00, 0, 0, 0, 0), 32'h0, 1'b1);
      rd(3'd2, v); chk("R12 init done", v, 32'h1);
      chk("R12 init length", 32'(expQ.size()), 32'h0);
      clearAll();
    end
    wr(3'd3, 32'h0);

    // R13: data hand-off
    chk("R13 no pulse before", 32'(xferCnt), 32'h0);
    issue(mk(17, 2'b10, 1, 1, 1, 1), 32'h0000_0200, 1'b0);
    respond(rsp48(17, 32'h0000_0900, 1, 1), 48, 2);
    chk("R13 pulse count read", 32'(xferCnt), 32'h1);
    chk("R13 direction read", {31'b0, lastDir}, 32'h1);
    issue(mk(24, 2'b00, 0, 0, 1, 0), 32'h0000_0400, 1'b0);
    @(negedge clk);
    chk("R13 pulse count write", 32'(xferCnt), 32'h2);
    chk("R13 direction write", {31'b0, lastDir}, 32'h0);
    clearAll();

    repeat (3) @(negedge clk);
    chk("R1 scoreboard drained", 32'(expQ.size()), 32'h0);
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
    $finish;
  end
endmodule